// File: doc/BRIEF.md
# Physical Interrupt Pending/Active Tracker

This block holds the per-line interrupt state that a distributor keeps for each physical interrupt input: a pending bit, an active bit, and the request it raises toward the CPU. Each line has its own trigger type. A level line keeps pending equal to the line itself. An edge line records rising edges. A message-style line has no active state at all.

The active bit masks delivery. A CPU acknowledge moves a requesting interrupt into the active state. Software can also force the active state directly, without any acknowledge, so that a device owned by a guest cannot keep interrupting the host. Only an explicit deactivate request clears the active bit, so end-of-interrupt and deactivation are separate steps. While a line is active, further edges accumulate as pending+active. When the line is deactivated, a level line is re-sampled and an edge line raises a new request only if an edge arrived while it was active.

The number of lines is a parameter. Each line is an independent copy of the same state cell.

Top module: `irq_pa_tracker`

## Requirements
- R1: In level mode (mode code 2'b00, and also 2'b11), the pending bit on the clock edge after a cycle equals the line value sampled in that cycle.
- R2: In edge mode (mode code 2'b01), a rising edge of the line (low in the previous cycle, high now) sets pending. This holds while the line is active too, which gives pending+active.
- R3: The request output of a line is high exactly when that line is pending and not active.
- R4: In level and edge modes, a set-active strobe sets the active bit on the next edge, with no acknowledge before it.
- R5: An acknowledge taken while the request is high sets active. In edge mode it also clears pending, unless a rising edge arrives in the same cycle, in which case pending stays set. An acknowledge while the request is low has no effect.
- R6: In level mode, after deactivation the request rises again only if the line is still high.
- R7: In edge mode, after deactivation the request rises again only if a rising edge was recorded while the line was active.
- R8: In message mode (mode code 2'b10), the active bit is always 0 and a set-active strobe is ignored. A rising edge sets pending, and an acknowledge clears pending and leaves the line inactive.
- R9: In level and edge modes, only the deactivate request clears the active bit, and an acknowledge never clears it. If set-active and deactivate arrive in the same cycle, active stays set.
- R10: Synchronous active-high reset clears pending, active and the stored line copy of every line.
- R11: The lines are independent. Stimulus on one line leaves the outputs of the other lines unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | NUM_IRQ | Device interrupt lines |
| mode_i | input | 2*NUM_IRQ | Trigger type per line; bits [2k+1:2k] belong to line k |
| ack_i | input | NUM_IRQ | CPU acknowledge per line |
| deact_i | input | NUM_IRQ | Deactivate request per line (from the host or a linked virtual entry) |
| set_act_i | input | NUM_IRQ | Software set-active strobe per line |
| pend_o | output | NUM_IRQ | Pending bit per line |
| act_o | output | NUM_IRQ | Active bit per line |
| irq_o | output | NUM_IRQ | Request toward the CPU per line |

## Verification
In edge mode, an acknowledge can land in the same cycle as a new rising edge. The acknowledge clears pending and the edge sets it, so the edge has to win and leave the line pending+active. The bench first makes the line pending and then drops the line. It then raises the acknowledge in the same cycle as the line returns high, and it expects both bits set and the request low. A second collision puts set-active and deactivate in the same cycle, and the bench checks that active stays set.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;

    typedef enum logic [1:0] {
        TRIG_LEVEL = 2'b00,
        TRIG_EDGE  = 2'b01,
        TRIG_MSG   = 2'b10,
        TRIG_ALT   = 2'b11
    } trig_mode_e;

    typedef struct packed {
        logic pend;
        logic act;
    } irq_state_t;

    localparam irq_state_t IRQ_IDLE = '{pend: 1'b0, act: 1'b0};

    function automatic logic mode_is_edge(input trig_mode_e m);
        return m == TRIG_EDGE;
    endfunction

    function automatic logic mode_is_msg(input trig_mode_e m);
        return m == TRIG_MSG;
    endfunction

    function automatic logic mode_is_level(input trig_mode_e m);
        return (m == TRIG_LEVEL) || (m == TRIG_ALT);
    endfunction

    function automatic logic state_wants_cpu(input irq_state_t s);
        return s.pend & ~s.act;
    endfunction

endpackage

// File: rtl/irq_edge_sampler.sv
module irq_edge_sampler #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] line_i,
    output logic [WIDTH-1:0] rise_o
);
    logic [WIDTH-1:0] line_q;

    always_ff @(posedge clk) begin
        if (rst) line_q <= '0;
        else     line_q <= line_i;
    end

    assign rise_o = line_i & ~line_q;

endmodule

// File: rtl/irq_state_cell.sv
module irq_state_cell
    import irq_trk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  trig_mode_e mode_i,
    input  logic       line_i,
    input  logic       rise_i,
    input  logic       ack_i,
    input  logic       deact_i,
    input  logic       set_act_i,
    output irq_state_t state_o
);
    irq_state_t st_q, st_d;
    logic       ack_take;

    assign ack_take = ack_i & state_wants_cpu(st_q);

    always_comb begin
        st_d = st_q;
        if (mode_is_level(mode_i)) begin
            st_d.pend = line_i;
        end else begin
            if (ack_take) st_d.pend = 1'b0;
            if (rise_i)   st_d.pend = 1'b1;
        end
        if (mode_is_msg(mode_i)) begin
            st_d.act = 1'b0;
        end else begin
            if (deact_i)              st_d.act = 1'b0;
            if (ack_take | set_act_i) st_d.act = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= IRQ_IDLE;
        else     st_q <= st_d;
    end

    assign state_o = st_q;

    a_r4_set_active: assert property (@(posedge clk) disable iff (rst)
        (set_act_i && !mode_is_msg(mode_i)) |=> st_q.act);

    a_r9_only_deact_clears: assert property (@(posedge clk) disable iff (rst)
        (st_q.act && !deact_i && !mode_is_msg(mode_i)) |=> st_q.act);

    a_r8_msg_no_active: assert property (@(posedge clk) disable iff (rst)
        mode_is_msg(mode_i) |=> !st_q.act);

    a_r2_edge_in_active: assert property (@(posedge clk) disable iff (rst)
        (mode_is_edge(mode_i) && st_q.act && rise_i && !deact_i) |=> (st_q.pend && st_q.act));

    a_r5_ack_activates: assert property (@(posedge clk) disable iff (rst)
        (ack_i && st_q.pend && !st_q.act && !mode_is_msg(mode_i)) |=> st_q.act);

endmodule

// File: rtl/irq_req_merge.sv
module irq_req_merge
    import irq_trk_pkg::*;
#(
    parameter int WIDTH = 2
) (
    input  irq_state_t [WIDTH-1:0] state_i,
    output logic       [WIDTH-1:0] pend_o,
    output logic       [WIDTH-1:0] act_o,
    output logic       [WIDTH-1:0] irq_o
);
    for (genvar k = 0; k < WIDTH; k++) begin : g_out
        assign pend_o[k] = state_i[k].pend;
        assign act_o[k]  = state_i[k].act;
        assign irq_o[k]  = state_wants_cpu(state_i[k]);
    end
endmodule

// File: rtl/irq_pa_tracker.sv
module irq_pa_tracker
    import irq_trk_pkg::*;
#(
    parameter int NUM_IRQ = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_IRQ-1:0]   line_i,
    input  logic [2*NUM_IRQ-1:0] mode_i,
    input  logic [NUM_IRQ-1:0]   ack_i,
    input  logic [NUM_IRQ-1:0]   deact_i,
    input  logic [NUM_IRQ-1:0]   set_act_i,
    output logic [NUM_IRQ-1:0]   pend_o,
    output logic [NUM_IRQ-1:0]   act_o,
    output logic [NUM_IRQ-1:0]   irq_o
);
    localparam int MODE_W = 2;

    logic       [NUM_IRQ-1:0] rise;
    irq_state_t [NUM_IRQ-1:0] cell_st;

    irq_edge_sampler #(.WIDTH(NUM_IRQ)) u_sampler (
        .clk    (clk),
        .rst    (rst),
        .line_i (line_i),
        .rise_o (rise)
    );

    for (genvar k = 0; k < NUM_IRQ; k++) begin : g_cell
        trig_mode_e cell_mode;
        assign cell_mode = trig_mode_e'(mode_i[MODE_W*k +: MODE_W]);

        irq_state_cell u_cell (
            .clk       (clk),
            .rst       (rst),
            .mode_i    (cell_mode),
            .line_i    (line_i[k]),
            .rise_i    (rise[k]),
            .ack_i     (ack_i[k]),
            .deact_i   (deact_i[k]),
            .set_act_i (set_act_i[k]),
            .state_o   (cell_st[k])
        );
    end

    irq_req_merge #(.WIDTH(NUM_IRQ)) u_merge (
        .state_i (cell_st),
        .pend_o  (pend_o),
        .act_o   (act_o),
        .irq_o   (irq_o)
    );

    a_r3_no_req_when_active: assert property (@(posedge clk) disable iff (rst)
        (irq_o & act_o) == '0);

    a_r10_reset_idle: assert property (@(posedge clk)
        rst |=> (pend_o == '0 && act_o == '0));

endmodule

// File: tb/irq_pa_tracker_test.sv
module irq_pa_tracker_test;
    localparam int N = 2;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] line, ack, deact, setact;
    logic [2*N-1:0] mode;
    logic [N-1:0] pend_o, act_o, irq_o;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    irq_pa_tracker #(.NUM_IRQ(N)) uut (
        .clk(clk), .rst(rst), .line_i(line), .mode_i(mode), .ack_i(ack),
        .deact_i(deact), .set_act_i(setact), .pend_o(pend_o), .act_o(act_o),
        .irq_o(irq_o)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic ep, input logic ea, input logic ei);
        tests++;
        if (pend_o[0] !== ep || act_o[0] !== ea || irq_o[0] !== ei) begin
            fails++;
            $display("FAIL %s: pend/act/irq = %b%b%b expected %b%b%b",
                     tag, pend_o[0], act_o[0], irq_o[0], ep, ea, ei);
        end
    endtask

    task automatic do_reset(input logic [1:0] m0);
        rst = 1'b1; line = '0; ack = '0; deact = '0; setact = '0;
        mode = {2'b00, m0};
        step(); step();
        rst = 1'b0;
        step();
    endtask

    task automatic t_reset();
        do_reset(2'b00);
        chk("R10 reset idle", 0, 0, 0);
    endtask

    task automatic t_level();
        do_reset(2'b00);
        line[0] = 1; step();
        chk("R1 level pend follows line", 1, 0, 1);
        ack[0] = 1; step(); ack[0] = 0;
        chk("R3 active masks request", 1, 1, 0);
        deact[0] = 1; step(); deact[0] = 0;
        chk("R6 line still high re-requests", 1, 0, 1);
        ack[0] = 1; step(); ack[0] = 0;
        line[0] = 0; step();
        chk("R1 level pend drops with line", 0, 1, 0);
        deact[0] = 1; step(); deact[0] = 0;
        chk("R6 line low no new request", 0, 0, 0);
    endtask

    task automatic t_edge();
        do_reset(2'b01);
        line[0] = 1; step();
        chk("R2 rising edge sets pending", 1, 0, 1);
        ack[0] = 1; step(); ack[0] = 0;
        chk("R5 edge ack clears pend sets act", 0, 1, 0);
        line[0] = 0; step();
        line[0] = 1; step();
        chk("R2 edge while active gives pend+act", 1, 1, 0);
        deact[0] = 1; step(); deact[0] = 0;
        chk("R7 recorded edge re-requests", 1, 0, 1);
        ack[0] = 1; step(); ack[0] = 0;
        line[0] = 0;
        deact[0] = 1; step(); deact[0] = 0;
        chk("R7 no edge no new request", 0, 0, 0);
    endtask

    task automatic t_collision();
        do_reset(2'b01);
        ack[0] = 1; step(); ack[0] = 0;
        chk("R5 ack without request ignored", 0, 0, 0);
        line[0] = 1; step();
        line[0] = 0; step();
        line[0] = 1; ack[0] = 1; step(); ack[0] = 0;
        chk("R5 ack with same-cycle edge keeps pend", 1, 1, 0);
    endtask

    task automatic t_setact();
        do_reset(2'b01);
        setact[0] = 1; step(); setact[0] = 0;
        chk("R4 set-active without ack", 0, 1, 0);
        line[0] = 1; step();
        chk("R2 edge after set-active", 1, 1, 0);
        setact[0] = 1; deact[0] = 1; step(); setact[0] = 0; deact[0] = 0;
        chk("R9 set-active beats deactivate", 1, 1, 0);
        ack[0] = 1; step(); ack[0] = 0;
        chk("R9 ack does not clear active", 1, 1, 0);
        deact[0] = 1; step(); deact[0] = 0;
        chk("R9 deactivate clears active", 1, 0, 1);
    endtask

    task automatic t_msg();
        do_reset(2'b10);
        line[0] = 1; step();
        chk("R8 msg edge sets pending", 1, 0, 1);
        setact[0] = 1; step(); setact[0] = 0;
        chk("R8 msg set-active ignored", 1, 0, 1);
        ack[0] = 1; step(); ack[0] = 0;
        chk("R8 msg ack leaves inactive", 0, 0, 0);
    endtask

    task automatic t_indep();
        do_reset(2'b00);
        line[1] = 1; step();
        tests++;
        if (pend_o !== 2'b10 || irq_o !== 2'b10) begin
            fails++;
            $display("FAIL R11 lines independent: pend=%b irq=%b expected 10 10", pend_o, irq_o);
        end
        setact[1] = 1; step(); setact[1] = 0;
        tests++;
        if (act_o !== 2'b10 || irq_o !== 2'b00) begin
            fails++;
            $display("FAIL R11 set-active one line: act=%b irq=%b expected 10 00", act_o, irq_o);
        end
    endtask

    initial begin
        t_reset();
        t_level();
        t_edge();
        t_collision();
        t_setact();
        t_msg();
        t_indep();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #2ms;
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule